// File: doc/BRIEF.md
# Bit-Serial First-Order Recursive Filter Section

This block computes one first-order recursive filter section on bit-serial data. Each word time it accepts a 24-bit two's complement input sample x(n) and a previous state z(n-1). It forms a weighted sum p = f·x(n) + b·z(n-1) and scales p down by a programmable power of two (q = p / 2^j). Adding a·z(n-1) to q gives the new state z(n). The output is y(n) = c·z(n) + d·z(n-1) + e·(z(n-1) / 2^k). Every coefficient is restricted to {-1, 0, +1} (b, a, d, e) or to {0, 1} (f, c). Each coefficient is applied through the operand-disable, add and subtract controls of a serial adder/subtractor, so the datapath has no multiplier.

All serial data moves least significant bit first, framed by a word-start marker. A single serial control line delivers the coefficients and both shift amounts during one word, and they govern the data word that follows. Results are produced one word after their inputs. A source-select pin picks the previous state from an input pin or from the section's own state loop. In the loop mode the section runs as a free-standing recursive filter.

Top module: `bsf_section`

## Requirements
- R1: A data word is W=24 bits wide, two's complement, least significant bit first, with one bit per clock. `wstart` is high during bit slot 0 of every word, words follow one another every W cycles, and all serial ports use this same framing.
- R2: During the slots of input word n, `tp1_n` carries p(n) = f·x(n) + b·z(n-1) modulo 2^24, in the same cycles as the inputs.
- R3: During word n+1, `tp2_n` carries q(n) = p(n) shifted right arithmetically by j. This copies the sign bit and rounds toward minus infinity.
- R4: During word n+1, `z_n` carries z(n) = q(n) + a·z(n-1) modulo 2^24.
- R5: During word n+1, `y_n` carries y(n) = c·z(n) + d·z(n-1) + e·(z(n-1) arithmetically shifted right by k), modulo 2^24.
- R6: Each signed coefficient is set by a disable bit and a sign bit. A high disable bit makes the coefficient 0. Otherwise a high sign bit gives +1 (add) and a low sign bit gives -1 (subtract).
- R7: Each of f and c is set by one bit. Low means the operand is used (coefficient 1) and high means it is ignored (coefficient 0).
- R8: The control word is sent on `cfg_in` in slots 0 to 17 of word n-1, and the values take effect for input word n. The slot assignment is: 0 f-ignore, 1 b-disable, 2 b-sign, 3 a-disable, 4 a-sign, 5 c-ignore, 6 d-disable, 7 d-sign, 8 e-disable, 9 e-sign, 10-13 j (LSB first), 14-17 k (LSB first). Slots 18 to 23 of `cfg_in` are ignored.
- R9: `x_n`, `zp_n`, `z_n`, `y_n`, `tp1_n` and `tp2_n` are active-low: a low level stands for a data bit of 1.
- R10: When `zsrc_ext` is high, z(n-1) is taken from `zp_n`. When it is low, the value on `zp_n` is ignored and z(n-1) for word n is the z(n-1) being driven on `z_n` in that same slot, so the section iterates z(n) on its own outputs.
- R11: Reset is synchronous and active high. It sets all coefficients and shifts to 0 and clears the stored words. While reset is held, and during the first word after reset, every output carries the value 0 (all lines high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| wstart | input | 1 | Word-start marker, high in bit slot 0 |
| cfg_in | input | 1 | Serial control word for the next data word |
| zsrc_ext | input | 1 | High: z(n-1) from `zp_n`; low: from the internal loop |
| x_n | input | 1 | Serial input sample, active-low |
| zp_n | input | 1 | Serial external previous state, active-low |
| z_n | output | 1 | Serial new state z(n), active-low |
| y_n | output | 1 | Serial section output y(n), active-low |
| tp1_n | output | 1 | Serial weighted sum p, active-low |
| tp2_n | output | 1 | Serial scaled sum q, active-low |

## Verification
At every word boundary, three events fall on the same clock edge: the coefficient and shift set changes over, the hold registers capture the last bit, and each serial adder reloads its carry for slot 0. A carry left over from the previous word's operation, or a coefficient taken from the wrong word, would corrupt only the low bits. The bench provokes this by changing every coefficient and both shift amounts on each back-to-back word, across all 324 coefficient combinations, with extreme and negative operands mixed in. Every word's four serial results are compared with values the bench computes arithmetically. A final run in loop mode drives random data on the ignored state pin and checks that the state recursion continues unaffected.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    // Width of each programmable shift amount
    localparam int SHIFT_W  = 4;
    // Number of serial control bits carried per word
    localparam int CFG_BITS = 10 + 2 * SHIFT_W;

    // Bit slot of every control field within the control word
    localparam int SL_F_OFF  = 0;
    localparam int SL_B_ZERO = 1;
    localparam int SL_B_PLUS = 2;
    localparam int SL_A_ZERO = 3;
    localparam int SL_A_PLUS = 4;
    localparam int SL_C_OFF  = 5;
    localparam int SL_D_ZERO = 6;
    localparam int SL_D_PLUS = 7;
    localparam int SL_E_ZERO = 8;
    localparam int SL_E_PLUS = 9;
    localparam int SL_J      = 10;
    localparam int SL_K      = 10 + SHIFT_W;

    typedef logic [SHIFT_W-1:0] shamt_t;

    // Signed coefficient: zero forces 0, otherwise plus selects +1 / -1
    typedef struct packed {
        logic zero;
        logic plus;
    } tcoef_t;

    typedef struct packed {
        logic   f_off;
        tcoef_t b;
        tcoef_t a;
        logic   c_off;
        tcoef_t d;
        tcoef_t e;
        shamt_t j;
        shamt_t k;
    } sect_cfg_t;

    function automatic sect_cfg_t cfg_decode(input logic [CFG_BITS-1:0] raw);
        sect_cfg_t c;
        c.f_off  = raw[SL_F_OFF];
        c.b.zero = raw[SL_B_ZERO];
        c.b.plus = raw[SL_B_PLUS];
        c.a.zero = raw[SL_A_ZERO];
        c.a.plus = raw[SL_A_PLUS];
        c.c_off  = raw[SL_C_OFF];
        c.d.zero = raw[SL_D_ZERO];
        c.d.plus = raw[SL_D_PLUS];
        c.e.zero = raw[SL_E_ZERO];
        c.e.plus = raw[SL_E_PLUS];
        c.j      = raw[SL_J +: SHIFT_W];
        c.k      = raw[SL_K +: SHIFT_W];
        return c;
    endfunction

    // Control word giving every coefficient and shift the value zero
    function automatic logic [CFG_BITS-1:0] cfg_idle_raw();
        logic [CFG_BITS-1:0] r;
        r            = '0;
        r[SL_F_OFF]  = 1'b1;
        r[SL_B_ZERO] = 1'b1;
        r[SL_A_ZERO] = 1'b1;
        r[SL_C_OFF]  = 1'b1;
        r[SL_D_ZERO] = 1'b1;
        r[SL_E_ZERO] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/bsf_framer.sv
module bsf_framer #(
    parameter int W = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wstart,
    output logic [$clog2(W)-1:0] slot,
    output logic                 first,
    output logic                 last
);
    localparam int             IW        = $clog2(W);
    localparam logic [IW-1:0]  LAST_SLOT = IW'(W - 1);

    logic [IW-1:0] cnt_q;

    always_comb begin
        slot  = wstart ? '0 : cnt_q;
        first = (slot == '0);
        last  = (slot == LAST_SLOT);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (last) cnt_q <= '0;
        else           cnt_q <= slot + 1'b1;
    end

    // R1
    marker_align_chk: assert property (@(posedge clk) disable iff (rst)
        wstart |-> cnt_q == '0);

endmodule

// File: rtl/bsf_addsub.sv
module bsf_addsub
    import bsf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   first,
    input  logic   a,
    input  logic   b,
    input  tcoef_t tc,
    output logic   s
);
    logic opb;
    logic cin;
    logic cy_q;

    always_comb begin
        opb = tc.zero ? 1'b0 : (tc.plus ? b : ~b);
        // slot 0 starts from the reload value: 1 when subtracting
        cin = first ? (~tc.zero & ~tc.plus) : cy_q;
        s   = a ^ opb ^ cin;
    end

    always_ff @(posedge clk) begin
        if (rst) cy_q <= 1'b0;
        else     cy_q <= (a & opb) | (a & cin) | (opb & cin);
    end

endmodule

// File: rtl/bsf_word_hold.sv
module bsf_word_hold #(
    parameter int W    = 24,
    parameter int NTAP = 1,
    parameter int SW   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_in,
    input  logic                 last,
    input  logic [$clog2(W)-1:0] slot,
    input  logic [NTAP*SW-1:0]   shamt,
    output logic [NTAP-1:0]      tap
);
    localparam int               IW   = $clog2(W);
    localparam int               SUMW = ((IW > SW) ? IW : SW) + 1;
    localparam logic [SUMW-1:0]  TOP  = SUMW'(W - 1);

    logic [W-1:0] col_q;
    logic [W-1:0] col_d;
    logic [W-1:0] hold_q;

    assign col_d = {bit_in, col_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            hold_q <= '0;
        end else begin
            col_q <= col_d;
            if (last) hold_q <= col_d;
        end
    end

    // Each tap reads the held word shifted right, replicating the sign bit
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        logic [SUMW-1:0] sum;
        logic [IW-1:0]   idx;
        assign sum    = SUMW'(slot) + SUMW'(shamt[g*SW +: SW]);
        assign idx    = (sum > TOP) ? IW'(W - 1) : sum[IW-1:0];
        assign tap[g] = hold_q[idx];
    end

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(hold_q));

endmodule

// File: rtl/bsf_cfg_rx.sv
module bsf_cfg_rx
    import bsf_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_in,
    input  logic [$clog2(W)-1:0] slot,
    input  logic                 last,
    output sect_cfg_t            cfg_s1,
    output sect_cfg_t            cfg_s2
);
    localparam int            IW    = $clog2(W);
    localparam logic [IW-1:0] NBITS = IW'(CFG_BITS);

    logic [CFG_BITS-1:0] raw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= cfg_idle_raw();
            cfg_s1 <= cfg_decode(cfg_idle_raw());
            cfg_s2 <= cfg_decode(cfg_idle_raw());
        end else begin
            if (slot < NBITS) raw_q[slot] <= cfg_in;
            if (last) begin
                cfg_s1 <= cfg_decode(raw_q);
                cfg_s2 <= cfg_s1;
            end
        end
    end

    // R8
    cfg_advance_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> cfg_s2 == $past(cfg_s1));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(cfg_s1));

endmodule

// File: rtl/bsf_section.sv
module bsf_section
    import bsf_pkg::*;
#(
    parameter int W = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic wstart,
    input  logic cfg_in,
    input  logic zsrc_ext,
    input  logic x_n,
    input  logic zp_n,
    output logic z_n,
    output logic y_n,
    output logic tp1_n,
    output logic tp2_n
);
    localparam int IW = $clog2(W);

    logic [IW-1:0] slot;
    logic          first;
    logic          last;
    sect_cfg_t     cfg_s1;
    sect_cfg_t     cfg_s2;

    logic          x_bit;
    logic          x_gated;
    logic          zp_bit;
    logic          p_bit;
    logic [0:0]    q_tap;
    logic [1:0]    zh_tap;
    logic          z_bit;
    logic          z_gated;
    logic          cd_bit;
    logic          y_bit;

    bsf_framer #(.W(W)) u_framer (
        .clk(clk), .rst(rst), .wstart(wstart),
        .slot(slot), .first(first), .last(last)
    );

    bsf_cfg_rx #(.W(W)) u_cfg (
        .clk(clk), .rst(rst), .cfg_in(cfg_in), .slot(slot), .last(last),
        .cfg_s1(cfg_s1), .cfg_s2(cfg_s2)
    );

    // Stage 1: weighted sum of the input and the previous state
    always_comb begin
        x_bit   = ~x_n;
        x_gated = cfg_s1.f_off ? 1'b0 : x_bit;
        zp_bit  = zsrc_ext ? ~zp_n : z_bit;
        z_gated = cfg_s2.c_off ? 1'b0 : z_bit;
    end

    bsf_addsub u_add_p (
        .clk(clk), .rst(rst), .first(first),
        .a(x_gated), .b(zp_bit), .tc(cfg_s1.b), .s(p_bit)
    );

    // One word of storage for the sum and for the previous state
    bsf_word_hold #(.W(W), .NTAP(1), .SW(SHIFT_W)) u_hold_p (
        .clk(clk), .rst(rst), .bit_in(p_bit), .last(last), .slot(slot),
        .shamt(cfg_s2.j), .tap(q_tap)
    );

    bsf_word_hold #(.W(W), .NTAP(2), .SW(SHIFT_W)) u_hold_z (
        .clk(clk), .rst(rst), .bit_in(zp_bit), .last(last), .slot(slot),
        .shamt({cfg_s2.k, shamt_t'(0)}), .tap(zh_tap)
    );

    // Stage 2: new state and section output
    bsf_addsub u_add_z (
        .clk(clk), .rst(rst), .first(first),
        .a(q_tap[0]), .b(zh_tap[0]), .tc(cfg_s2.a), .s(z_bit)
    );

    bsf_addsub u_add_cd (
        .clk(clk), .rst(rst), .first(first),
        .a(z_gated), .b(zh_tap[0]), .tc(cfg_s2.d), .s(cd_bit)
    );

    bsf_addsub u_add_y (
        .clk(clk), .rst(rst), .first(first),
        .a(cd_bit), .b(zh_tap[1]), .tc(cfg_s2.e), .s(y_bit)
    );

    always_comb begin
        tp1_n = ~p_bit;
        tp2_n = ~q_tap[0];
        z_n   = ~z_bit;
        y_n   = ~y_bit;
    end

    // R2
    tp1_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_s1.f_off && cfg_s1.b.zero) |-> tp1_n);

    // R5
    y_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_s2.c_off && cfg_s2.d.zero && cfg_s2.e.zero) |-> y_n);

endmodule

// File: tb/bsf_section_test.sv
module bsf_section_test;

    localparam int CLK_P = 10;
    localparam int W     = 24;
    localparam int NCOMB = 324;
    localparam int NINT  = 40;
    localparam int NW    = 1 + NCOMB + NINT;
    localparam int CB    = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wstart = 1'b0;
    logic cfg_in = 1'b0;
    logic zsrc_ext = 1'b1;
    logic x_n = 1'b1;
    logic zp_n = 1'b1;
    logic z_n, y_n, tp1_n, tp2_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int cf_f [0:NW+1];
    int cf_b [0:NW+1];
    int cf_a [0:NW+1];
    int cf_c [0:NW+1];
    int cf_d [0:NW+1];
    int cf_e [0:NW+1];
    int cf_j [0:NW+1];
    int cf_k [0:NW+1];
    logic [CB-1:0] craw [0:NW+1];
    logic          md   [0:NW+1];
    logic [W-1:0]  vx   [0:NW+1];
    logic [W-1:0]  vzp  [0:NW+1];
    logic [W-1:0]  etp1 [0:NW+1];
    logic [W-1:0]  etp2 [0:NW+1];
    logic [W-1:0]  ez   [0:NW+1];
    logic [W-1:0]  ey   [0:NW+1];

    always #(CLK_P/2) clk = ~clk;

    bsf_section #(.W(W)) uut (
        .clk(clk), .rst(rst), .wstart(wstart), .cfg_in(cfg_in),
        .zsrc_ext(zsrc_ext), .x_n(x_n), .zp_n(zp_n),
        .z_n(z_n), .y_n(y_n), .tp1_n(tp1_n), .tp2_n(tp2_n)
    );

    function automatic logic [W-1:0] scale(input int c, input logic [W-1:0] v);
        if (c == 0) return '0;
        if (c > 0)  return v;
        return W'(0) - v;
    endfunction

    function automatic logic [W-1:0] asr(input logic [W-1:0] v, input int s);
        logic signed [W-1:0] t;
        t = v;
        t = t >>> s;
        return t;
    endfunction

    // Control word layout from R6, R7 and R8
    function automatic logic [CB-1:0] enc(input int f, input int b, input int a,
                                          input int c, input int d, input int e,
                                          input int j, input int k);
        logic [CB-1:0] r;
        r        = '0;
        r[0]     = (f == 0);
        r[1]     = (b == 0);
        r[2]     = (b > 0);
        r[3]     = (a == 0);
        r[4]     = (a > 0);
        r[5]     = (c == 0);
        r[6]     = (d == 0);
        r[7]     = (d > 0);
        r[8]     = (e == 0);
        r[9]     = (e > 0);
        r[13:10] = 4'(j);
        r[17:14] = 4'(k);
        return r;
    endfunction

    function automatic int unsigned rnd(input int unsigned s);
        int unsigned t;
        t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Stimulus and expected values
    initial begin
        int unsigned seed;
        logic [W-1:0] prevz;
        logic [W-1:0] zp;
        seed  = 32'h1234_5678;
        prevz = '0;
        for (int w = 0; w <= NW + 1; w++) begin
            int idx;
            if (w == 0 || w >= NW) begin
                cf_f[w] = 0; cf_b[w] = 0; cf_a[w] = 0; cf_c[w] = 0;
                cf_d[w] = 0; cf_e[w] = 0; cf_j[w] = 0; cf_k[w] = 0;
            end else begin
                idx = (w <= NCOMB) ? (w - 1) : ((w * 37) % NCOMB);
                cf_f[w] = idx % 2;
                cf_b[w] = (idx / 2) % 3 - 1;
                cf_a[w] = (idx / 6) % 3 - 1;
                cf_c[w] = (idx / 18) % 2;
                cf_d[w] = (idx / 36) % 3 - 1;
                cf_e[w] = (idx / 108) % 3 - 1;
                cf_j[w] = (w * 5) % 16;
                cf_k[w] = (w * 3 + 1) % 16;
            end
            craw[w] = enc(cf_f[w], cf_b[w], cf_a[w], cf_c[w], cf_d[w], cf_e[w], cf_j[w], cf_k[w]);
            md[w] = (w == 0 || w <= NCOMB || w >= NW);
            seed = rnd(seed); vx[w]  = seed[W-1:0];
            seed = rnd(seed); vzp[w] = seed[W-1:0];
            if (w % 11 == 3) vx[w]  = 24'h7FFFFF;
            if (w % 13 == 5) vx[w]  = 24'h800000;
            if (w % 17 == 0) vzp[w] = 24'h800000;
            if (w % 19 == 2) vzp[w] = 24'hFFFFFF;
            // R10: in loop mode the previous state is the last z computed
            zp = md[w] ? vzp[w] : prevz;
            etp1[w] = scale(cf_f[w], vx[w]) + scale(cf_b[w], zp);
            etp2[w] = asr(etp1[w], cf_j[w]);
            ez[w]   = etp2[w] + scale(cf_a[w], zp);
            ey[w]   = scale(cf_c[w], ez[w]) + scale(cf_d[w], zp)
                    + scale(cf_e[w], asr(zp, cf_k[w]));
            prevz   = ez[w];
        end
    end

    // Drive and observe
    initial begin
        logic [W-1:0] g_tp1, g_tp2, g_z, g_y;
        #1;
        repeat (3) @(negedge clk);
        // R11: reset state, all outputs at value 0 (lines high, R9)
        checks++;
        if ({tp1_n, tp2_n, z_n, y_n} !== 4'b1111) begin
            errors++;
            $display("FAIL R11 reset outputs actual=%b expected=1111", {tp1_n, tp2_n, z_n, y_n});
        end
        for (int w = 0; w <= NW; w++) begin
            for (int s = 0; s < W; s++) begin
                @(negedge clk);
                rst      = 1'b0;
                // R1: marker in slot 0; R9: data lines inverted
                wstart   = (s == 0);
                x_n      = ~vx[w][s];
                zp_n     = ~vzp[w][s];
                zsrc_ext = md[w];
                cfg_in   = (s < CB) ? craw[w + 1][s] : 1'b1;
                #1;
                g_tp1[s] = ~tp1_n;
                g_tp2[s] = ~tp2_n;
                g_z[s]   = ~z_n;
                g_y[s]   = ~y_n;
            end
            if (w < NW)
                check($sformatf("R2 R6 R7 p word %0d", w), g_tp1, etp1[w]);
            if (w == 0) begin
                check("R11 q first word", g_tp2, '0);
                check("R11 z first word", g_z, '0);
                check("R11 y first word", g_y, '0);
            end else begin
                check($sformatf("R3 R8 q word %0d", w - 1), g_tp2, etp2[w - 1]);
                if (md[w - 1])
                    check($sformatf("R4 R6 z word %0d", w - 1), g_z, ez[w - 1]);
                else
                    check($sformatf("R4 R10 z loop word %0d", w - 1), g_z, ez[w - 1]);
                check($sformatf("R5 R7 R8 y word %0d", w - 1), g_y, ey[w - 1]);
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule